// File: doc/BRIEF.md
# DMA Channel Instruction Executor

This block runs a small slice of a DMA controller's instruction set for a single thread. It pulls instruction bytes one at a time from a valid/ready byte stream. It holds a 32-bit source address register and a 32-bit destination address register, and it decodes three operations:

- a negative add of a 16-bit immediate to one of the two address registers;
- a sequence end;
- a peripheral flush.

The thread kind is given on an input: manager or channel. The negative add is rejected in a manager thread.

A sequence end does not stop the thread at once. The thread first waits until the outstanding-transfer count input reaches zero. It then enters Stopped, and on entry it pulses a data-FIFO flush and a cache invalidate. A peripheral flush clears the stored level-known flag of the named peripheral. It then issues a resend request on a valid/ready handshake, and fetching stalls until that request is accepted. Once the thread is stopped or faulted, it stays there until a synchronous restart.

Top module: `dma_thread_exec`

## Requirements
- R1: After reset both address registers are 0, `stopped`, `faulted`, `rsnd_valid`, `fifo_flush` and `cache_inval` are 0, `lvl_known` is all zero, and `ib_ready` is 1.
- R2: Opcode byte 0x5C followed by two immediate bytes (low byte first) adds {16'hFFFF, imm} to the source register. Opcode 0x5E does the same to the destination register. The other register is left unchanged, and the new value is visible the cycle after the last byte is accepted.
- R3: When `is_manager`=1, an accepted 0x5C or 0x5E sets `faulted` on the next cycle and leaves both address registers unchanged.
- R4: Address arithmetic wraps modulo 2^32, and the carry out is discarded.
- R5: Opcode 0x00 is legal in both thread kinds. `stopped` rises only on the cycle after a cycle in which the thread was draining and `outstanding` was 0.
- R6: `fifo_flush` and `cache_inval` are high for exactly the first cycle of `stopped`.
- R7: Opcode 0x35 followed by a byte whose bits [7:3] name a peripheral clears that peripheral's bit in `lvl_known`. It then drives `rsnd_valid` with `rsnd_periph` set to that number, and holds both until `rsnd_ready` is seen.
- R8: While `rsnd_valid` is high, `ib_ready` is 0.
- R9: Any opcode byte other than 0x00, 0x35, 0x5C and 0x5E sets `faulted` on the next cycle.
- R10: `stopped` and `faulted` are never high together. Each one, with `ib_ready` low, holds until `restart` is sampled high. After restart, fetching resumes and both address registers keep their values.
- R11: `lvl_valid` sets `lvl_known[lvl_id]` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous return to fetch from any state |
| is_manager | input | 1 | 1 = manager thread, 0 = channel thread |
| ib_valid | input | 1 | Instruction byte valid |
| ib_data | input | 8 | Instruction byte |
| ib_ready | output | 1 | Executor accepts a byte |
| outstanding | input | CNT_W | Count of transfers still in flight |
| lvl_valid | input | 1 | Peripheral level report strobe |
| lvl_id | input | PERIPH_W | Peripheral number of the level report |
| lvl_known | output | 2**PERIPH_W | Per-peripheral level-known flags |
| rsnd_valid | output | 1 | Resend request valid |
| rsnd_ready | input | 1 | Resend request accepted |
| rsnd_periph | output | PERIPH_W | Peripheral number of the resend request |
| src_addr | output | ADDR_W | Source address register |
| dst_addr | output | ADDR_W | Destination address register |
| stopped | output | 1 | Thread is stopped |
| faulted | output | 1 | Thread is faulted |
| fifo_flush | output | 1 | One-cycle data FIFO flush |
| cache_inval | output | 1 | One-cycle cache invalidate |

## Verification
The assertions assume the following about the inputs:
- `ib_data` is stable whenever `ib_valid` is high.
- `is_manager` does not change in the middle of an instruction.
- `outstanding` only moves toward zero once an end instruction is being drained.

The bench drives all inputs on the falling edge. It holds each byte until it is accepted, and changes the thread kind and the count only between instructions. It asserts `restart` only while the thread sits stopped or faulted, so the request-hold property is never cut short by a restart.

// File: rtl/dma_thread_exec.sv
module dma_thread_exec #(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 8,
  parameter int PERIPH_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   restart,
  input  logic                   is_manager,
  input  logic                   ib_valid,
  input  logic [7:0]             ib_data,
  output logic                   ib_ready,
  input  logic [CNT_W-1:0]       outstanding,
  input  logic                   lvl_valid,
  input  logic [PERIPH_W-1:0]    lvl_id,
  output logic [2**PERIPH_W-1:0] lvl_known,
  output logic                   rsnd_valid,
  input  logic                   rsnd_ready,
  output logic [PERIPH_W-1:0]    rsnd_periph,
  output logic [ADDR_W-1:0]      src_addr,
  output logic [ADDR_W-1:0]      dst_addr,
  output logic                   stopped,
  output logic                   faulted,
  output logic                   fifo_flush,
  output logic                   cache_inval
);
  localparam int NPER = 2**PERIPH_W;
  localparam int EXT_W = ADDR_W - 16;
  localparam logic [7:0] OP_END = 8'h00;
  localparam logic [7:0] OP_FLP = 8'h35;
  localparam logic [7:0] OP_ADS = 8'h5C;
  localparam logic [7:0] OP_ADD = 8'h5E;

  typedef enum logic [2:0] {
    S_OP, S_IMM0, S_IMM1, S_PER, S_REQ, S_DRAIN, S_STOP, S_FAULT
  } state_t;

  state_t state;
  logic   sel_dst;
  logic [7:0] imm_lo;
  logic take;
  logic [ADDR_W-1:0] addend, base;

  assign ib_ready   = (state == S_OP) || (state == S_IMM0) || (state == S_IMM1) || (state == S_PER);
  assign take       = ib_valid && ib_ready;
  assign rsnd_valid = (state == S_REQ);
  assign stopped    = (state == S_STOP);
  assign faulted    = (state == S_FAULT);
  assign addend     = {{EXT_W{1'b1}}, ib_data, imm_lo};
  assign base       = sel_dst ? dst_addr : src_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_OP;
      sel_dst     <= 1'b0;
      imm_lo      <= '0;
      src_addr    <= '0;
      dst_addr    <= '0;
      rsnd_periph <= '0;
      fifo_flush  <= 1'b0;
      cache_inval <= 1'b0;
    end else begin
      fifo_flush  <= 1'b0;
      cache_inval <= 1'b0;
      if (restart) begin
        state <= S_OP;
      end else begin
        case (state)
          S_OP: if (take) begin
            case (ib_data)
              OP_END: state <= S_DRAIN;
              OP_FLP: state <= S_PER;
              OP_ADS, OP_ADD: begin
                sel_dst <= ib_data[1];
                state   <= is_manager ? S_FAULT : S_IMM0;
              end
              default: state <= S_FAULT;
            endcase
          end
          S_IMM0: if (take) begin
            imm_lo <= ib_data;
            state  <= S_IMM1;
          end
          S_IMM1: if (take) begin
            if (sel_dst) dst_addr <= base + addend;
            else         src_addr <= base + addend;
            state <= S_OP;
          end
          S_PER: if (take) begin
            rsnd_periph <= ib_data[7:8-PERIPH_W];
            state       <= S_REQ;
          end
          S_REQ: if (rsnd_ready) state <= S_OP;
          S_DRAIN: if (outstanding == '0) begin
            state       <= S_STOP;
            fifo_flush  <= 1'b1;
            cache_inval <= 1'b1;
          end
          default: state <= state;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NPER; g++) begin : g_lvl
    logic clr;
    assign clr = (state == S_PER) && take && !restart && (ib_data[7:8-PERIPH_W] == PERIPH_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    lvl_known[g] <= 1'b0;
      else if (clr)                                  lvl_known[g] <= 1'b0;
      else if (lvl_valid && lvl_id == PERIPH_W'(g))  lvl_known[g] <= 1'b1;
    end
  end
endmodule

module dma_thread_exec_chk #(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 8,
  parameter int PERIPH_W = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                restart,
  input logic                is_manager,
  input logic                ib_valid,
  input logic [7:0]          ib_data,
  input logic                ib_ready,
  input logic [CNT_W-1:0]    outstanding,
  input logic                rsnd_valid,
  input logic                rsnd_ready,
  input logic [PERIPH_W-1:0] rsnd_periph,
  input logic [ADDR_W-1:0]   src_addr,
  input logic [ADDR_W-1:0]   dst_addr,
  input logic                stopped,
  input logic                faulted,
  input logic                fifo_flush,
  input logic                cache_inval
);
  AST_MGR_ADD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (ib_valid && ib_ready && is_manager && !restart && !stopped && !faulted && !rsnd_valid &&
     (ib_data == 8'h5C || ib_data == 8'h5E) && $past(ib_ready) && !$past(ib_valid && ib_ready))
    |=> faulted && $stable(src_addr) && $stable(dst_addr)); // R3
  AST_STOP_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |-> $past(outstanding) == '0); // R5
  AST_STOP_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |-> fifo_flush && cache_inval); // R6
  AST_PULSE_ONLY_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_flush || cache_inval) |-> $rose(stopped)); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsnd_valid && !rsnd_ready && !restart) |=> rsnd_valid && $stable(rsnd_periph)); // R7
  AST_REQ_STALLS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    rsnd_valid |-> !ib_ready); // R8
  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !restart) |=> stopped && !ib_ready); // R10
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (faulted && !restart) |=> faulted && !ib_ready); // R10
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(stopped && faulted)); // R10
endmodule

bind dma_thread_exec dma_thread_exec_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PERIPH_W(PERIPH_W)) u_chk (.*);

// File: tb/sim_dma_thread_exec.sv
module sim_dma_thread_exec;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  typedef struct packed {
    logic        dst;
    logic [15:0] imm;
    logic [31:0] esrc;
    logic [31:0] edst;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 16'hFFF0, 32'hFFFFFFF0, 32'h00000000},
    '{1'b1, 16'hFFFF, 32'hFFFFFFF0, 32'hFFFFFFFF},
    '{1'b0, 16'h0000, 32'hFFFEFFF0, 32'hFFFFFFFF},
    '{1'b1, 16'h8001, 32'hFFFEFFF0, 32'hFFFF8000},
    '{1'b0, 16'h1234, 32'hFFFE1224, 32'hFFFF8000},
    '{1'b1, 16'h0010, 32'hFFFE1224, 32'hFFFE8010}
  };

  logic clk = 0, rst_n = 0, restart = 0, is_manager = 0;
  logic ib_valid = 0, lvl_valid = 0, rsnd_ready = 0;
  logic [7:0] ib_data = 0, outstanding = 0;
  logic [4:0] lvl_id = 0;
  logic ib_ready, rsnd_valid, stopped, faulted, fifo_flush, cache_inval;
  logic [31:0] lvl_known, src_addr, dst_addr;
  logic [4:0] rsnd_periph;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_thread_exec u0 (.*);

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    ib_valid = 1; ib_data = b;
    while (!ib_ready) @(negedge clk);
    @(negedge clk);
    ib_valid = 0;
  endtask

  task automatic do_restart();
    restart = 1; @(negedge clk); restart = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(src_addr == 0 && dst_addr == 0, "R1 addr", src_addr | dst_addr, 0);
    check(!stopped && !faulted && !rsnd_valid && !fifo_flush && !cache_inval, "R1 status",
          {stopped, faulted, rsnd_valid, fifo_flush, cache_inval}, 0);
    check(ib_ready && lvl_known == 0, "R1 ready", {ib_ready, lvl_known[30:0]}, 32'h80000000);

    // R2 R4 vector table
    for (int i = 0; i < NVEC; i++) begin
      send(VECS[i].dst ? 8'h5E : 8'h5C);
      send(VECS[i].imm[7:0]);
      send(VECS[i].imm[15:8]);
      check(src_addr == VECS[i].esrc, "R2/R4 src", src_addr, VECS[i].esrc);
      check(dst_addr == VECS[i].edst, "R2/R4 dst", dst_addr, VECS[i].edst);
    end

    // R11 level report
    lvl_valid = 1; lvl_id = 5'd5; @(negedge clk); lvl_valid = 0;
    check(lvl_known == 32'h20, "R11 set", lvl_known, 32'h20);

    // R7 R8 flush peripheral
    send(8'h35);
    send(8'h28);
    check(rsnd_valid && rsnd_periph == 5'd5, "R7 request", {rsnd_valid, rsnd_periph}, {1'b1, 5'd5});
    check(lvl_known == 0, "R7 clear", lvl_known, 0);
    check(!ib_ready, "R8 stall", ib_ready, 0);
    repeat (3) @(negedge clk);
    check(rsnd_valid && rsnd_periph == 5'd5 && !ib_ready, "R7 hold", {ib_ready, rsnd_valid}, 1);
    rsnd_ready = 1; @(negedge clk); rsnd_ready = 0;
    check(!rsnd_valid && ib_ready, "R7 accept", {rsnd_valid, ib_ready}, 1);

    // R5 R6 end with outstanding transfers
    outstanding = 8'd3;
    send(8'h00);
    repeat (3) @(negedge clk);
    check(!stopped && !fifo_flush, "R5 drain wait", {stopped, fifo_flush}, 0);
    outstanding = 8'd0;
    @(negedge clk);
    check(stopped, "R5 stop", stopped, 1);
    check(fifo_flush && cache_inval, "R6 pulses", {fifo_flush, cache_inval}, 3);
    @(negedge clk);
    check(!fifo_flush && !cache_inval, "R6 single", {fifo_flush, cache_inval}, 0);
    check(stopped && !ib_ready && !faulted, "R10 stopped hold", {stopped, ib_ready, faulted}, 4);
    do_restart();
    check(!stopped && ib_ready, "R10 restart", {stopped, ib_ready}, 1);
    check(src_addr == 32'hFFFE1224 && dst_addr == 32'hFFFE8010, "R10 keep", src_addr, 32'hFFFE1224);

    // R3 negative add in manager thread
    is_manager = 1;
    send(8'h5E);
    check(faulted && !ib_ready, "R3 fault", {faulted, ib_ready}, 2);
    check(dst_addr == 32'hFFFE8010 && src_addr == 32'hFFFE1224, "R3 unchanged", dst_addr, 32'hFFFE8010);
    repeat (2) @(negedge clk);
    check(faulted && !stopped, "R10 fault hold", {faulted, stopped}, 2);
    do_restart();

    // R5 end legal in manager thread
    send(8'h00);
    @(negedge clk);
    check(stopped && !faulted, "R5 manager end", {stopped, faulted}, 2);
    do_restart();
    is_manager = 0;

    // R9 unknown opcode
    send(8'hA7);
    check(faulted, "R9 unknown", faulted, 1);
    do_restart();
    check(!faulted && ib_ready, "R9 restart", {faulted, ib_ready}, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule